// File: doc/BRIEF.md
# Handshaked Fall-Through FIFO Register

This block is a small first-in first-out store of sixteen 4-bit words. Writer and reader may run at unrelated rates, and each side paces itself with its own strobe pin. A word is taken from the data inputs on the rising edge of the write strobe. The oldest valid word is always shown on the data outputs, and a falling edge of the read strobe retires it. Two flags carry the handshake. The space flag says that another word can be accepted. The data flag says that the output stage holds a valid word.

The strobes need not be related to the system clock. Each one passes through a two-flop synchronizer, and its edge is detected on the system clock. A write edge and a read edge can both be serviced in the same clock. An active-high master reset marks every entry invalid but leaves the stored words in place. An enable pin can float the output bus so that several units can share it. Because the flags are the whole handshake, units can be chained through them to make a deeper store. They can also be placed side by side to make a wider word.

Top module: `handshake_fifo`

## Requirements
- R1: The store holds exactly 16 words. From empty, 16 accepted writes drop the space flag, and no 17th word is ever stored.
- R2: A word on the data inputs is stored on a low-to-high transition of the write strobe, provided the space flag is high. Into an empty store, that word appears on the data outputs.
- R3: A high-to-low transition of the read strobe, while the data flag is high, retires the head word. The words are presented in the order they were written, and this holds across pointer wrap-around.
- R4: The space flag is low exactly when all 16 entries are valid. The data flag is high exactly when at least one entry is valid. Neither flag moves unless a strobe is accepted or master reset is applied.
- R5: A write strobe that arrives while the space flag is low is ignored. Neither the contents nor the flags change.
- R6: A read strobe that arrives while the data flag is low is ignored. Neither the contents nor the flags change.
- R7: While master reset is high, the space flag is high and the data flag is low. Reset only marks the entries invalid. The read and write positions return to entry 0, and the stored words are kept, so the output afterwards shows the last word written into entry 0.
- R8: While the output enable pin is high, the data outputs are high-impedance (4'bzzzz). While it is low, they drive the head word. The pin does not affect the contents.
- R9: A write edge and a read edge detected in the same clock are both honoured. With one word stored, the result is one word, and that word is the new one.
- R10: Two units chained through their flags pass a sequence from the first unit to the second in order, with no loss and no duplication. The first unit's data flag paces the transfer into the second unit. The second unit's space flag gates retirement from the first unit.
- R11: An accepted strobe transition changes the flags on the third rising clock edge after it. The synchronizer accounts for two of those edges and the update register for the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| masterReset | input | 1 | Active-high reset; invalidates all entries |
| shiftIn | input | 1 | Write strobe, acts on its rising edge |
| dataIn | input | 4 | Word to be written |
| inReady | output | 1 | Space flag: high when a word can be accepted |
| shiftOut | input | 1 | Read strobe, acts on its falling edge |
| outEnable | input | 1 | High floats the data outputs |
| dataOut | output | 4 | Head word, or high-impedance |
| outReady | output | 1 | Data flag: high when the head word is valid |

## Verification
A strobe transition is sampled by two synchronizer flops. Its edge is then acted on at the third rising clock edge, so the flags and the head word are due right after that edge. The latency check drives the strobe on a falling edge. It then samples on the following falling edges, requiring the flags unchanged after the second rising edge and updated after the third. Every other scenario holds each strobe level for four clocks before it reads the ports, which leaves one clock of margin beyond the due cycle. The output enable acts combinationally and is checked half a clock after it changes.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  // Commands from control to datapath, one clock wide each
  typedef struct packed {
    logic push;   // store the input word at the tail
    logic pop;    // retire the head word
    logic clear;  // invalidate all entries, reset positions
  } fifoCmd_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2,
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic strobeRaw,
  output logic edgeSeen
);
  logic [STAGES-1:0] chain;
  logic              prevLevel;

  always_ff @(posedge clk) begin
    chain     <= {chain[STAGES-2:0], strobeRaw};
    prevLevel <= chain[STAGES-1];
  end

  generate
    if (RISING) begin : g_rise
      assign edgeSeen = chain[STAGES-1] & ~prevLevel;
    end else begin : g_fall
      assign edgeSeen = ~chain[STAGES-1] & prevLevel;
    end
  endgenerate
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic     clk,
  input  logic     masterReset,
  input  logic     shiftIn,
  input  logic     shiftOut,
  output logic     inReady,
  output logic     outReady,
  output fifoCmd_t cmd
);
  logic          wrEdge, rdEdge;
  logic [CW-1:0] validCount;
  logic          notFull, notEmpty;

  strobe_sync #(.STAGES(SYNC_STAGES), .RISING(1'b1)) u_wrSync (
    .clk(clk), .strobeRaw(shiftIn), .edgeSeen(wrEdge)
  );
  strobe_sync #(.STAGES(SYNC_STAGES), .RISING(1'b0)) u_rdSync (
    .clk(clk), .strobeRaw(shiftOut), .edgeSeen(rdEdge)
  );

  assign notFull  = (validCount != CW'(DEPTH));
  assign notEmpty = (validCount != '0);
  assign inReady  = masterReset | notFull;
  assign outReady = ~masterReset & notEmpty;

  always_comb begin
    cmd.clear = masterReset;
    cmd.push  = wrEdge & inReady & ~masterReset;
    cmd.pop   = rdEdge & outReady & ~masterReset;
  end

  always_ff @(posedge clk) begin
    if (cmd.clear) begin
      validCount <= '0;
    end else begin
      case ({cmd.push, cmd.pop})
        2'b10:   validCount <= validCount + 1'b1;
        2'b01:   validCount <= validCount - 1'b1;
        default: validCount <= validCount;
      endcase
    end
  end
endmodule

// File: rtl/fifo_data.sv
module fifo_data
  import fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  fifoCmd_t         cmd,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] headWord
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wrPos, rdPos;

  function automatic logic [PW-1:0] nextPos(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (cmd.clear) begin
      wrPos <= '0;
      rdPos <= '0;
    end else begin
      if (cmd.push) wrPos <= nextPos(wrPos);
      if (cmd.pop)  rdPos <= nextPos(rdPos);
    end
  end

  // Storage is never cleared: reset only invalidates via the positions
  always_ff @(posedge clk) begin
    if (cmd.push && !cmd.clear) store[wrPos] <= dataIn;
  end

  assign headWord = store[rdPos];
endmodule

// File: rtl/handshake_fifo.sv
module handshake_fifo
  import fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             masterReset,
  input  logic             shiftIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             inReady,
  input  logic             shiftOut,
  input  logic             outEnable,
  output logic [WIDTH-1:0] dataOut,
  output logic             outReady
);
  fifoCmd_t         cmd;
  logic [WIDTH-1:0] headWord;

  fifo_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .masterReset(masterReset), .shiftIn(shiftIn),
    .shiftOut(shiftOut), .inReady(inReady), .outReady(outReady), .cmd(cmd)
  );

  fifo_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk(clk), .cmd(cmd), .dataIn(dataIn), .headWord(headWord)
  );

  assign dataOut = outEnable ? {WIDTH{1'bz}} : headWord;
endmodule

// File: rtl/handshake_fifo_check.sv
module handshake_fifo_check
  import fifo_pkg::*;
(
  input logic     clk,
  input logic     masterReset,
  input logic     inReady,
  input logic     outReady,
  input fifoCmd_t cmd
);
  assert_reset_flags_R7: assert property (@(posedge clk)
    masterReset |-> (inReady && !outReady));

  assert_full_has_data_R4: assert property (@(posedge clk) disable iff (masterReset)
    !inReady |-> outReady);

  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (masterReset)
    (!cmd.push && !cmd.pop) |=> ($stable(inReady) && $stable(outReady)));

  assert_full_ignore_R5: assert property (@(posedge clk) disable iff (masterReset)
    (!inReady && !cmd.pop) |=> !inReady);

  assert_empty_ignore_R6: assert property (@(posedge clk) disable iff (masterReset)
    (!outReady && !cmd.push) |=> !outReady);

  assert_data_rise_R2: assert property (@(posedge clk) disable iff (masterReset)
    $rose(outReady) |-> $past(cmd.push));
endmodule

bind handshake_fifo handshake_fifo_check chk (
  .clk(clk), .masterReset(masterReset), .inReady(inReady),
  .outReady(outReady), .cmd(cmd)
);

// File: tb/handshake_fifo_test.sv
`timescale 1ns/1ps
module handshake_fifo_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       masterReset = 1'b1;
  logic       shiftIn = 1'b0, shiftOut = 1'b1, outEnable = 1'b0;
  logic [3:0] dataIn = 4'h0;
  logic       inReady, outReady;
  logic [3:0] dataOut;

  logic       nShiftIn = 1'b0, nShiftOut = 1'b1;
  logic [3:0] nDataIn = 4'h0;
  logic       nInReady, nOutReady;
  logic [3:0] nDataOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  handshake_fifo uut (
    .clk(clk), .masterReset(masterReset), .shiftIn(shiftIn), .dataIn(dataIn),
    .inReady(inReady), .shiftOut(shiftOut), .outEnable(outEnable),
    .dataOut(dataOut), .outReady(outReady)
  );

  handshake_fifo uutNext (
    .clk(clk), .masterReset(masterReset), .shiftIn(nShiftIn), .dataIn(nDataIn),
    .inReady(nInReady), .shiftOut(nShiftOut), .outEnable(1'b0),
    .dataOut(nDataOut), .outReady(nOutReady)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushWord(input logic [3:0] d);
    dataIn = d; shiftIn = 1'b1; waitNeg(4);
    shiftIn = 1'b0; waitNeg(4);
  endtask

  task automatic popWord();
    shiftOut = 1'b0; waitNeg(4);
    shiftOut = 1'b1; waitNeg(4);
  endtask

  task automatic doReset();
    masterReset = 1'b1; waitNeg(3);
    check("R7 space flag during reset", {7'b0, inReady}, 8'h01);
    check("R7 data flag during reset", {7'b0, outReady}, 8'h00);
    masterReset = 1'b0; waitNeg(2);
  endtask

  task automatic testResetState();
    waitNeg(4);
    check("R7 reset space flag", {7'b0, inReady}, 8'h01);
    check("R7 reset data flag", {7'b0, outReady}, 8'h00);
    masterReset = 1'b0; waitNeg(2);
    check("R4 idle empty data flag", {7'b0, outReady}, 8'h00);
  endtask

  task automatic testLatency();
    dataIn = 4'h6; shiftIn = 1'b1;
    waitNeg(2);
    check("R11 data flag before third edge", {7'b0, outReady}, 8'h00);
    waitNeg(1);
    check("R11 data flag after third edge", {7'b0, outReady}, 8'h01);
    check("R2 first word on output", {4'h0, dataOut}, 8'h06);
    shiftIn = 1'b0; waitNeg(4);
    shiftOut = 1'b0;
    waitNeg(2);
    check("R11 data flag before third read edge", {7'b0, outReady}, 8'h01);
    waitNeg(1);
    check("R11 data flag after third read edge", {7'b0, outReady}, 8'h00);
    shiftOut = 1'b1; waitNeg(4);
  endtask

  task automatic testResetKeepsData();
    doReset();
    pushWord(4'h9);
    pushWord(4'h3);
    doReset();
    check("R7 flags after reset", {6'b0, inReady, outReady}, 8'h02);
    check("R7 entry 0 kept", {4'h0, dataOut}, 8'h09);
    pushWord(4'h5);
    check("R7 new word into entry 0", {4'h0, dataOut}, 8'h05);
    popWord();
    check("R6 empty after single pop", {7'b0, outReady}, 8'h00);
  endtask

  task automatic testFillDrain();
    pushWord(4'h2); pushWord(4'h4); popWord(); popWord();
    for (int i = 0; i < 16; i++) begin
      pushWord(4'((i * 7 + 1) & 15));
      if (i == 14) check("R4 space flag with 15 words", {7'b0, inReady}, 8'h01);
    end
    check("R1 space flag low at 16 words", {7'b0, inReady}, 8'h00);
    pushWord(4'hE);
    check("R5 space flag still low", {7'b0, inReady}, 8'h00);
    check("R5 head unchanged", {4'h0, dataOut}, 8'h01);
    for (int i = 0; i < 16; i++) begin
      check("R3 order through wrap", {4'h0, dataOut}, 8'((i * 7 + 1) & 15));
      popWord();
    end
    check("R1 empty after 16 pops", {6'b0, inReady, outReady}, 8'h02);
    popWord();
    check("R6 flags unchanged", {6'b0, inReady, outReady}, 8'h02);
    pushWord(4'hB);
    check("R6 one word after ignored pop", {4'h0, dataOut}, 8'h0B);
    popWord();
    check("R6 single word retired", {7'b0, outReady}, 8'h00);
  endtask

  task automatic testOutEnable();
    pushWord(4'hC);
    outEnable = 1'b1; waitNeg(1);
    check("R8 floated output", {4'h0, dataOut}, {4'h0, 4'bzzzz});
    outEnable = 1'b0; waitNeg(1);
    check("R8 driven output", {4'h0, dataOut}, 8'h0C);
    check("R8 data flag kept", {7'b0, outReady}, 8'h01);
  endtask

  task automatic testSimultaneous();
    dataIn = 4'hD; shiftIn = 1'b1; shiftOut = 1'b0;
    waitNeg(4);
    shiftIn = 1'b0; shiftOut = 1'b1; waitNeg(4);
    check("R9 one word remains", {7'b0, outReady}, 8'h01);
    check("R9 new word at head", {4'h0, dataOut}, 8'h0D);
    popWord();
    check("R9 empty after final pop", {7'b0, outReady}, 8'h00);
  endtask

  task automatic testCascade();
    int moved = 0;
    for (int i = 0; i < 5; i++) pushWord(4'(i + 10));
    for (int guard = 0; guard < 40 && uut.outReady; guard++) begin
      while (!nInReady) waitNeg(1);
      nDataIn = dataOut; nShiftIn = 1'b1; waitNeg(4);
      nShiftIn = 1'b0; waitNeg(1);
      shiftOut = 1'b0; waitNeg(4);
      shiftOut = 1'b1; waitNeg(4);
      moved++;
    end
    check("R10 words moved", 8'(moved), 8'h05);
    check("R10 first unit empty", {7'b0, outReady}, 8'h00);
    for (int i = 0; i < 5; i++) begin
      check("R10 chained order", {3'b0, nOutReady, nDataOut}, {4'h1, 4'(i + 10)});
      nShiftOut = 1'b0; waitNeg(4);
      nShiftOut = 1'b1; waitNeg(4);
    end
    check("R10 second unit drained", {7'b0, nOutReady}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testResetState();
    testLatency();
    testResetKeepsData();
    testFillDrain();
    testOutEnable();
    popWord();
    pushWord(4'h7);
    testSimultaneous();
    testCascade();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule